// File: doc/BRIEF.md
# Accumulator ALU with Split Carry and Borrow Flags

This block is the purely combinational arithmetic and logic stage of a small single-accumulator processor. From the accumulator, a memory operand, the current carry bit and a 4-bit operation code, it forms the new accumulator value. It also forms the next values of five status flags: negative, zero, carry, overflow and borrow.

Each flag comes with its own write enable. The surrounding register file uses these enables to decide which flags to capture. Flags the operation does not touch keep their stored value because their enable stays low.

Addition reports its unsigned overflow on the carry flag, and subtraction reports its own on a separate borrow flag, so neither operation disturbs the other's flag. Shifts and rotates pass the bit that falls off the end through carry. Rotates bring the old carry back in at the opposite end, which lets software chain shifts across several bytes.

Top module: `alu_flag_unit`

## Requirements
- R1: Operation code 0 (load) gives result = operand, with only the negative and zero enables high.
- R2: Operation code 1 (add) gives result = (acc + operand) mod 256, carry = bit 8 of the 9-bit sum, with the negative, zero, carry and overflow enables high and the borrow enable low.
- R3: For add, overflow is 1 exactly when acc[7] equals operand[7] and result[7] differs from acc[7].
- R4: Operation code 2 (subtract) gives result = (acc - operand) mod 256, borrow = 1 exactly when acc < operand as unsigned numbers, with the negative, zero, borrow and overflow enables high and the carry enable low.
- R5: For subtract, overflow is 1 exactly when acc[7] differs from operand[7] and result[7] differs from acc[7].
- R6: Operation codes 3 (OR), 4 (AND) and 5 (NOT of acc) give the bitwise result, with only the negative and zero enables high.
- R7: Operation code 6 (logical shift right) gives result = acc >> 1 with bit 7 = 0 and carry = acc[0]. Operation code 7 (logical shift left) gives result = acc << 1 with bit 0 = 0 and carry = acc[7]. Both raise only the negative, zero and carry enables.
- R8: Operation code 8 (rotate right) gives result = {carry_in, acc[7:1]} and carry = acc[0]. Operation code 9 (rotate left) gives result = {acc[6:0], carry_in} and carry = acc[7]. Both raise only the negative, zero and carry enables.
- R9: Whenever the negative enable is high, the negative output equals result[7]. Whenever the zero enable is high, the zero output is 1 exactly when the result is 0.
- R10: Operation codes 10 to 15 do not write the accumulator. For them, result = acc and all five flag enables are low.
- R11: A flag whose enable is low drives a fixed value: carry repeats carry_in, and negative, zero, overflow and borrow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| mem_i | input | 8 | Memory operand |
| carry_i | input | 1 | Current stored carry flag |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | New accumulator value |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| b_o | output | 1 | Next borrow flag |
| n_we_o | output | 1 | Negative flag write enable |
| z_we_o | output | 1 | Zero flag write enable |
| c_we_o | output | 1 | Carry flag write enable |
| v_we_o | output | 1 | Overflow flag write enable |
| b_we_o | output | 1 | Borrow flag write enable |

## Verification
The hardest cases to reach are the boundaries where the unsigned and signed views of add and subtract disagree. Examples are 0x80 - 0x01, which sets overflow but not borrow, and 0x00 - 0x01, which sets borrow but not overflow, together with rotates whose incoming carry differs from the outgoing bit. The stimulus first walks a fixed list of such operand pairs through every operation code with carry_in both 0 and 1. It then sweeps pseudo-random operands from a shift register over all sixteen codes, comparing every output against an integer model on each clock.

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  input  logic         carry_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o,
  output logic         b_o,
  output logic         n_we_o,
  output logic         z_we_o,
  output logic         c_we_o,
  output logic         v_we_o,
  output logic         b_we_o
);
  localparam int MSB = W - 1;

  localparam logic [3:0] OP_LOAD = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_NOT  = 4'd5;
  localparam logic [3:0] OP_SHR  = 4'd6;
  localparam logic [3:0] OP_SHL  = 4'd7;
  localparam logic [3:0] OP_ROR  = 4'd8;
  localparam logic [3:0] OP_ROL  = 4'd9;

  logic [W:0]   sum, diff;
  logic [W-1:0] res;
  logic         c_new, v_new, b_new;
  logic         nz_en, c_en, v_en, b_en;

  assign sum  = {1'b0, acc_i} + {1'b0, mem_i};
  assign diff = {1'b0, acc_i} - {1'b0, mem_i};

  always_comb begin
    res   = acc_i;
    c_new = carry_i;
    v_new = 1'b0;
    b_new = 1'b0;
    nz_en = 1'b1;
    c_en  = 1'b0;
    v_en  = 1'b0;
    b_en  = 1'b0;
    case (op_i)
      OP_LOAD: res = mem_i;
      OP_ADD: begin
        res   = sum[MSB:0];
        c_new = sum[W];
        v_new = (acc_i[MSB] == mem_i[MSB]) && (sum[MSB] != acc_i[MSB]);
        c_en  = 1'b1;
        v_en  = 1'b1;
      end
      OP_SUB: begin
        res   = diff[MSB:0];
        b_new = diff[W];
        v_new = (acc_i[MSB] != mem_i[MSB]) && (diff[MSB] != acc_i[MSB]);
        b_en  = 1'b1;
        v_en  = 1'b1;
      end
      OP_OR:  res = acc_i | mem_i;
      OP_AND: res = acc_i & mem_i;
      OP_NOT: res = ~acc_i;
      OP_SHR: begin
        res   = {1'b0, acc_i[MSB:1]};
        c_new = acc_i[0];
        c_en  = 1'b1;
      end
      OP_SHL: begin
        res   = {acc_i[MSB-1:0], 1'b0};
        c_new = acc_i[MSB];
        c_en  = 1'b1;
      end
      OP_ROR: begin
        res   = {carry_i, acc_i[MSB:1]};
        c_new = acc_i[0];
        c_en  = 1'b1;
      end
      OP_ROL: begin
        res   = {acc_i[MSB-1:0], carry_i};
        c_new = acc_i[MSB];
        c_en  = 1'b1;
      end
      default: nz_en = 1'b0;
    endcase
  end

  assign res_o  = res;
  assign n_we_o = nz_en;
  assign z_we_o = nz_en;
  assign c_we_o = c_en;
  assign v_we_o = v_en;
  assign b_we_o = b_en;
  assign n_o    = nz_en & res[MSB];
  assign z_o    = nz_en & (res == '0);
  assign c_o    = c_new;
  assign v_o    = v_new;
  assign b_o    = b_new;
endmodule

module alu_flag_unit_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] acc_i,
  input logic [W-1:0] mem_i,
  input logic         carry_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         z_o,
  input logic         c_o,
  input logic         v_o,
  input logic         b_o,
  input logic         n_we_o,
  input logic         z_we_o,
  input logic         c_we_o,
  input logic         v_we_o,
  input logic         b_we_o
);
  localparam int MSB = W - 1;
  logic known;
  assign known = !$isunknown({acc_i, mem_i, carry_i, op_i});

  always_comb begin
    if (known) begin
      // R2
      add_carry_chk: assert (op_i != 4'd1 || ({c_o, res_o} == {1'b0, acc_i} + {1'b0, mem_i}))
        else $error("add result/carry mismatch");
      // R4
      sub_keeps_carry_chk: assert (op_i != 4'd2 || (!c_we_o && b_we_o && (res_o + mem_i == acc_i)))
        else $error("subtract touched carry");
      // R8
      ror_chk: assert (op_i != 4'd8 || (res_o[MSB] == carry_i && c_o == acc_i[0]))
        else $error("rotate right wrong");
      // R9
      neg_tracks_chk: assert (!n_we_o || n_o == res_o[MSB])
        else $error("negative flag off result");
      // R10
      idle_chk: assert (op_i < 4'd10 || ({n_we_o, z_we_o, c_we_o, v_we_o, b_we_o} == 5'b0 && res_o == acc_i))
        else $error("idle code wrote something");
      // R11
      hold_carry_chk: assert (c_we_o || c_o == carry_i)
        else $error("carry changed while disabled");
      // R11
      quiet_flags_chk: assert ((v_we_o || !v_o) && (b_we_o || !b_o))
        else $error("disabled flag not zero");
    end
  end
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (.*);

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc, mem;
  logic       cin;
  logic [3:0] op;
  logic [7:0] res;
  logic n, z, c, v, b, nw, zw, cw, vw, bw;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  alu_flag_unit u0 (
    .acc_i(acc), .mem_i(mem), .carry_i(cin), .op_i(op), .res_o(res),
    .n_o(n), .z_o(z), .c_o(c), .v_o(v), .b_o(b),
    .n_we_o(nw), .z_we_o(zw), .c_we_o(cw), .v_we_o(vw), .b_we_o(bw)
  );

  function automatic string tag_of(int o);
    case (o)
      0: return "R1";
      1: return "R2/R3";
      2: return "R4/R5";
      3, 4, 5: return "R6";
      6, 7: return "R7";
      8, 9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input int a, input int m, input int ci, input int o,
                       output int r, output int en, output int fl);
    int s, rn, rz, rc, rv, rb, wn, wc, wv, wb;
    r = a; rc = ci; rv = 0; rb = 0; wn = 1; wc = 0; wv = 0; wb = 0;
    case (o)
      0: r = m;
      1: begin
        s = a + m; r = s % 256; rc = (s > 255) ? 1 : 0;
        rv = (((a >= 128) == (m >= 128)) && ((r >= 128) != (a >= 128))) ? 1 : 0;
        wc = 1; wv = 1;
      end
      2: begin
        s = a - m; rb = (s < 0) ? 1 : 0; r = (s + 256) % 256;
        rv = (((a >= 128) != (m >= 128)) && ((r >= 128) != (a >= 128))) ? 1 : 0;
        wb = 1; wv = 1;
      end
      3: r = a | m;
      4: r = a & m;
      5: r = 255 - a;
      6: begin rc = a % 2; r = a / 2; wc = 1; end
      7: begin rc = a / 128; r = (a * 2) % 256; wc = 1; end
      8: begin rc = a % 2; r = a / 2 + ci * 128; wc = 1; end
      9: begin rc = a / 128; r = (a * 2) % 256 + ci; wc = 1; end
      default: wn = 0;
    endcase
    rn = (wn == 1 && r >= 128) ? 1 : 0;
    rz = (wn == 1 && r == 0) ? 1 : 0;
    en = wn * 16 + wn * 8 + wc * 4 + wv * 2 + wb;
    fl = rn * 16 + rz * 8 + rc * 4 + rv * 2 + rb;
  endtask

  task automatic apply(input int a, input int m, input int ci, input int o);
    int er, ee, ef, gen, gfl;
    @(posedge clk);
    acc = a[7:0]; mem = m[7:0]; cin = ci[0]; op = o[3:0];
    @(negedge clk);
    model(a, m, ci, o, er, ee, ef);
    gen = {27'd0, nw, zw, cw, vw, bw};
    gfl = {27'd0, n, z, c, v, b};
    checks++;
    if (int'(res) != er) begin
      errors++;
      $display("FAIL %s op=%0d acc=%02h mem=%02h cin=%0d result got %02h exp %02h",
               tag_of(o), o, a, m, ci, res, er);
    end
    checks++;
    if (gen != ee) begin
      errors++;
      $display("FAIL %s op=%0d enables (NZCVB) got %05b exp %05b", tag_of(o), o, gen[4:0], ee[4:0]);
    end
    checks++;
    if (gfl != ef) begin
      errors++;
      $display("FAIL %s/R9/R11 op=%0d acc=%02h mem=%02h cin=%0d flags (NZCVB) got %05b exp %05b",
               tag_of(o), o, a, m, ci, gfl[4:0], ef[4:0]);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end

  int pa[10] = '{8'h00, 8'hFF, 8'h7F, 8'h80, 8'h80, 8'h00, 8'h7F, 8'h55, 8'h01, 8'h80};
  int pm[10] = '{8'h00, 8'h01, 8'h01, 8'h80, 8'h01, 8'h01, 8'hFF, 8'hAA, 8'h01, 8'h7F};

  initial begin
    logic [15:0] lfsr;
    acc = '0; mem = '0; cin = 1'b0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state, load of zero: R1, R9
    apply(0, 0, 0, 0);
    // R3 add 7F+01 overflows, no carry
    apply(8'h7F, 8'h01, 0, 1);
    // R2 FF+01 carry, zero
    apply(8'hFF, 8'h01, 0, 1);
    // R5 80-01 overflow without borrow
    apply(8'h80, 8'h01, 1, 2);
    // R4 00-01 borrow without overflow, carry held at 1 (R11)
    apply(8'h00, 8'h01, 1, 2);
    // R8 rotate with incoming carry
    apply(8'h01, 8'h00, 1, 8);
    apply(8'h80, 8'h00, 1, 9);
    // R7 shifts ignore carry_in
    apply(8'h81, 8'h00, 1, 6);
    apply(8'h81, 8'h00, 1, 7);
    // R10 idle codes
    apply(8'h00, 8'hFF, 1, 15);
    for (int i = 0; i < 10; i++)
      for (int o = 0; o < 16; o++)
        for (int ci = 0; ci < 2; ci++)
          apply(pa[i], pm[i], ci, o);
    lfsr = 16'hACE1;
    for (int k = 0; k < 1200; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[3]), k % 16);
    end
    finish_run();
  end
endmodule